// File: doc/BRIEF.md
# Branch and Program-Counter Unit

This block holds the 64-bit program counter of a load/store RISC core and decides, for each issued instruction, the address to fetch next. Decode supplies a branch class (sequential, conditional branch, call-style unconditional branch, or register jump), a condition selector, the value of the register under test, a 21-bit displacement, a jump-target register value and the index of the link destination. The block updates the counter on the next clock edge when the enable is high.

Branch targets are the address of the following instruction plus the sign-extended displacement scaled to 4-byte words. That gives a reach of 2^20 instructions either way. Conditional branches can test bit 0 of the register, or compare the register as a signed number against zero. Unconditional branches and jumps hand back the address of the following instruction as a link value. The link write is dropped when its destination is the hardwired zero register.

Top module: `bpc_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, pc_o equals RESET_VEC with its two low bits cleared.
- R2: With en_i high and class_i = 0 (sequential), pc_o increases by 4 at the next clock edge.
- R3: With en_i low, pc_o keeps its value at the next clock edge, and taken_o and link_we_o are 0, whatever the other inputs are.
- R4: A taken conditional branch (class_i = 1) loads pc_o + 4 + (sign-extended disp_i × 4) at the next edge.
- R5: Condition codes 0 and 1 test bit 0 of test_val_i. Code 0 is taken when the bit is 0, and code 1 is taken when the bit is 1.
- R6: Condition codes 2 to 7 treat test_val_i as a signed 64-bit number against zero. The codes are 2 = equal, 3 = not equal, 4 = less than, 5 = less or equal, 6 = greater or equal, 7 = greater than.
- R7: A conditional branch whose condition fails sets taken_o = 0 and advances pc_o by 4.
- R8: An unconditional branch (class_i = 2) is always taken. It loads the same target as R4 and presents link_val_o = pc_o + 4 with link_we_o = 1.
- R9: A jump (class_i = 3) is taken and loads jump_val_i with its two low bits cleared. It presents link_val_o = pc_o + 4.
- R10: When link_idx_i is 31 (all ones), link_we_o stays 0 for every class.
- R11: The two low bits of pc_o are always 0.
- R12: The extreme displacements +2^20-1 and -2^20 reach exactly 4 × (2^20-1) bytes forward and 4 × 2^20 bytes back from the following instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Instruction issue enable; low holds the PC |
| class_i | input | 2 | 0 sequential, 1 conditional, 2 unconditional with link, 3 jump |
| cond_i | input | 3 | Condition code for conditional branches (see R5, R6) |
| test_val_i | input | 64 | Register value under test |
| disp_i | input | 21 | Signed word displacement |
| jump_val_i | input | 64 | Jump target register value |
| link_idx_i | input | 5 | Link destination register index |
| pc_o | output | 64 | Current program counter |
| taken_o | output | 1 | Current instruction redirects the PC |
| link_we_o | output | 1 | Link write request |
| link_val_o | output | 64 | Address of the following instruction |

## Verification
The assertions assume that reset is applied once at start-up. They also assume that class_i, cond_i and the operand inputs change only away from the rising edge, so that each edge samples one settled instruction. The bench drives every input on the falling edge. It samples taken_o and the link outputs one time unit later, and it samples pc_o one time unit after the rising edge. The bench never drives an undefined value onto the selector inputs. Displacements and jump values include the sign-boundary cases and misaligned low bits, so the alignment and reach properties are exercised at their limits.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    BR_SEQ  = 2'd0,
    BR_COND = 2'd1,
    BR_CALL = 2'd2,
    BR_JUMP = 2'd3
  } br_class_e;

  typedef enum logic [2:0] {
    CND_LOW_CLR = 3'd0,
    CND_LOW_SET = 3'd1,
    CND_EQ      = 3'd2,
    CND_NE      = 3'd3,
    CND_LT      = 3'd4,
    CND_LE      = 3'd5,
    CND_GE      = 3'd6,
    CND_GT      = 3'd7
  } br_cond_e;

  localparam int unsigned ALIGN_BITS = 2;
endpackage

// File: rtl/bpc_cond_eval.sv
module bpc_cond_eval #(
  parameter int unsigned XLEN = 64
) (
  input  logic [2:0]      cond_i,
  input  logic [XLEN-1:0] val_i,
  output logic            hit_o
);
  import bpc_pkg::*;

  logic neg, zero;
  br_cond_e cnd;

  assign neg  = val_i[XLEN-1];
  assign zero = ~|val_i;
  assign cnd  = br_cond_e'(cond_i);

  always_comb begin
    unique case (cnd)
      CND_LOW_CLR: hit_o = ~val_i[0];
      CND_LOW_SET: hit_o = val_i[0];
      CND_EQ:      hit_o = zero;
      CND_NE:      hit_o = ~zero;
      CND_LT:      hit_o = neg;
      CND_LE:      hit_o = neg | zero;
      CND_GE:      hit_o = ~neg;
      CND_GT:      hit_o = ~neg & ~zero;
      default:     hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bpc_target_gen.sv
module bpc_target_gen #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned DISP_W = 21
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   tgt_o
);
  import bpc_pkg::*;

  localparam int unsigned EXT_W = XLEN - DISP_W - ALIGN_BITS;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(1 << ALIGN_BITS);

  logic [XLEN-1:0] offset;

  // word displacement, sign-extended and scaled to bytes
  assign offset = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, {ALIGN_BITS{1'b0}}};
  assign seq_o  = pc_i + INSN_BYTES;
  assign tgt_o  = seq_o + offset;
endmodule

// File: rtl/bpc_pc_reg.sv
module bpc_pc_reg #(
  parameter int unsigned     XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [XLEN-1:0] next_i,
  output logic [XLEN-1:0] pc_o
);
  import bpc_pkg::*;

  localparam logic [XLEN-1:0] RST_ALIGNED =
    {RESET_VEC[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  logic [XLEN-ALIGN_BITS-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= RST_ALIGNED[XLEN-1:ALIGN_BITS];
    else if (load_i) pc_q <= next_i[XLEN-1:ALIGN_BITS];
  end

  assign pc_o = {pc_q, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/bpc_unit.sv
module bpc_unit #(
  parameter int unsigned     XLEN      = 64,
  parameter int unsigned     DISP_W    = 21,
  parameter int unsigned     REG_IDX_W = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 64'h0000_0000_0001_0000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [1:0]           class_i,
  input  logic [2:0]           cond_i,
  input  logic [XLEN-1:0]      test_val_i,
  input  logic [DISP_W-1:0]    disp_i,
  input  logic [XLEN-1:0]      jump_val_i,
  input  logic [REG_IDX_W-1:0] link_idx_i,
  output logic [XLEN-1:0]      pc_o,
  output logic                 taken_o,
  output logic                 link_we_o,
  output logic [XLEN-1:0]      link_val_o
);
  import bpc_pkg::*;

  localparam logic [REG_IDX_W-1:0] ZERO_REG = {REG_IDX_W{1'b1}};

  br_class_e       cls;
  logic            cond_hit, redirect, links;
  logic [XLEN-1:0] seq_pc, br_tgt, next_pc;

  assign cls = br_class_e'(class_i);

  bpc_cond_eval #(.XLEN(XLEN)) i_cond (
    .cond_i (cond_i),
    .val_i  (test_val_i),
    .hit_o  (cond_hit)
  );

  bpc_target_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) i_tgt (
    .pc_i   (pc_o),
    .disp_i (disp_i),
    .seq_o  (seq_pc),
    .tgt_o  (br_tgt)
  );

  always_comb begin
    redirect = 1'b0;
    links    = 1'b0;
    next_pc  = seq_pc;
    unique case (cls)
      BR_SEQ:  ;
      BR_COND: begin
        redirect = cond_hit;
        if (cond_hit) next_pc = br_tgt;
      end
      BR_CALL: begin
        redirect = 1'b1;
        links    = 1'b1;
        next_pc  = br_tgt;
      end
      BR_JUMP: begin
        redirect = 1'b1;
        links    = 1'b1;
        next_pc  = jump_val_i; // low bits dropped in pc register
      end
      default: ;
    endcase
  end

  bpc_pc_reg #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) i_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (en_i),
    .next_i (next_pc),
    .pc_o   (pc_o)
  );

  assign taken_o    = en_i & redirect;
  assign link_we_o  = en_i & links & (link_idx_i != ZERO_REG);
  assign link_val_o = seq_pc;
endmodule

// File: rtl/bpc_unit_chk.sv
module bpc_unit_chk #(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned DISP_W    = 21,
  parameter int unsigned REG_IDX_W = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic [1:0]           class_i,
  input logic [2:0]           cond_i,
  input logic [XLEN-1:0]      test_val_i,
  input logic [DISP_W-1:0]    disp_i,
  input logic [XLEN-1:0]      jump_val_i,
  input logic [REG_IDX_W-1:0] link_idx_i,
  input logic [XLEN-1:0]      pc_o,
  input logic                 taken_o,
  input logic                 link_we_o,
  input logic [XLEN-1:0]      link_val_o
);
  p_pc_aligned_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  p_hold_pc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_o));

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!taken_o && !link_we_o));

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && class_i == 2'd0) |=> pc_o == $past(pc_o) + 64'd4);

  p_fallthru_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && class_i == 2'd1 && !taken_o) |=> pc_o == $past(pc_o) + 64'd4);

  p_call_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && class_i == 2'd2) |-> taken_o);

  p_link_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_val_o == pc_o + 64'd4);

  p_jump_dest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && class_i == 2'd3) |=> pc_o[XLEN-1:2] == $past(jump_val_i[XLEN-1:2]));

  p_zero_link_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&link_idx_i) |-> !link_we_o);
endmodule

bind bpc_unit bpc_unit_chk #(
  .XLEN(XLEN), .DISP_W(DISP_W), .REG_IDX_W(REG_IDX_W)
) i_bpc_unit_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .class_i(class_i),
  .cond_i(cond_i), .test_val_i(test_val_i), .disp_i(disp_i),
  .jump_val_i(jump_val_i), .link_idx_i(link_idx_i), .pc_o(pc_o),
  .taken_o(taken_o), .link_we_o(link_we_o), .link_val_o(link_val_o)
);

// File: tb/test_bpc_unit.sv
`timescale 1ns/1ps
module test_bpc_unit;
  localparam logic [63:0] RST_VEC = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en;
  logic [1:0]  cls;
  logic [2:0]  cnd;
  logic [63:0] tval, jval;
  logic [20:0] disp;
  logic [4:0]  lidx;
  logic [63:0] pc, link_val;
  logic        taken, link_we;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_pc;
  bit done = 0;

  always #2.5 clk = ~clk;

  bpc_unit #(.RESET_VEC(RST_VEC)) i_bpc_unit (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .class_i(cls), .cond_i(cnd),
    .test_val_i(tval), .disp_i(disp), .jump_val_i(jval), .link_idx_i(lidx),
    .pc_o(pc), .taken_o(taken), .link_we_o(link_we), .link_val_o(link_val)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit cond_model(logic [2:0] c, logic [63:0] v);
    case (c)
      3'd0: return v[0] == 1'b0;
      3'd1: return v[0] == 1'b1;
      3'd2: return $signed(v) == 0;
      3'd3: return $signed(v) != 0;
      3'd4: return $signed(v) < 0;
      3'd5: return $signed(v) <= 0;
      3'd6: return $signed(v) >= 0;
      default: return $signed(v) > 0;
    endcase
  endfunction

  // issue one instruction, check combinational outputs then the new PC
  task automatic issue(string req, bit e, logic [1:0] c, logic [2:0] cc,
                       logic [63:0] tv, logic [20:0] d, logic [63:0] jv,
                       logic [4:0] li);
    logic [63:0] seq, tgt, nxt;
    bit          tk, lw;
    @(negedge clk);
    en = e; cls = c; cnd = cc; tval = tv; disp = d; jval = jv; lidx = li;
    seq = exp_pc + 64'd4;
    tgt = seq + {{41{d[20]}}, d, 2'b00};
    tk = 0; lw = 0; nxt = seq;
    case (c)
      2'd1: begin tk = cond_model(cc, tv); if (tk) nxt = tgt; end
      2'd2: begin tk = 1; lw = 1; nxt = tgt; end
      2'd3: begin tk = 1; lw = 1; nxt = {jv[63:2], 2'b00}; end
      default: ;
    endcase
    if (!e) begin tk = 0; lw = 0; nxt = exp_pc; end
    if (li == 5'd31) lw = 0;
    #1;
    check({req, " taken"}, 64'(taken), 64'(tk));
    check({req, " link_we"}, 64'(link_we), 64'(lw));
    if (lw) check({req, " link_val"}, link_val, seq);
    @(posedge clk); #1;
    exp_pc = nxt;
    check({req, " pc"}, pc, exp_pc);
    check("R11 pc aligned", 64'(pc[1:0]), 64'd0);
  endtask

  task automatic t_reset;
    check("R1 reset pc", pc, RST_VEC);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 pc after release", pc, RST_VEC);
    exp_pc = RST_VEC;
  endtask

  task automatic t_seq;
    for (int i = 0; i < 3; i++)
      issue("R2 sequential", 1, 2'd0, 3'd2, 64'd0, 21'h1F, 64'd0, 5'd1);
  endtask

  task automatic t_hold;
    issue("R3 disabled call", 0, 2'd2, 3'd0, 64'd0, 21'd100, 64'd0, 5'd26);
    issue("R3 disabled jump", 0, 2'd3, 3'd0, 64'd0, 21'd0, 64'hDEAD_0000, 5'd26);
    issue("R3 disabled cond", 0, 2'd1, 3'd2, 64'd0, 21'd8, 64'd0, 5'd1);
  endtask

  task automatic t_lowbit;
    issue("R5 R4 lowclr taken", 1, 2'd1, 3'd0, 64'd6, 21'd16, 64'd0, 5'd1);
    issue("R5 R7 lowclr fail", 1, 2'd1, 3'd0, 64'd7, 21'd16, 64'd0, 5'd1);
    issue("R5 R4 lowset taken", 1, 2'd1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 21'h1FFFF8, 64'd0, 5'd1);
    issue("R5 R7 lowset fail", 1, 2'd1, 3'd1, 64'h8000_0000_0000_0000, 21'd4, 64'd0, 5'd1);
  endtask

  task automatic t_signed;
    logic [63:0] vals [5];
    vals[0] = 64'd0; vals[1] = 64'd5; vals[2] = -64'sd3;
    vals[3] = 64'h8000_0000_0000_0000; vals[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    for (int c = 2; c < 8; c++)
      for (int v = 0; v < 5; v++)
        issue("R6 signed cond", 1, 2'd1, 3'(c), vals[v],
              (v % 2 == 0) ? 21'd12 : 21'h1FFFF0, 64'd0, 5'd1);
  endtask

  task automatic t_reach;
    issue("R12 max forward", 1, 2'd2, 3'd0, 64'd0, 21'h0FFFFF, 64'd0, 5'd26);
    issue("R12 max backward", 1, 2'd2, 3'd0, 64'd0, 21'h100000, 64'd0, 5'd26);
    issue("R12 max backward again", 1, 2'd1, 3'd2, 64'd0, 21'h100000, 64'd0, 5'd1);
  endtask

  task automatic t_call;
    issue("R8 call link", 1, 2'd2, 3'd3, 64'd0, 21'd40, 64'd0, 5'd26);
    issue("R10 call zero reg", 1, 2'd2, 3'd3, 64'd0, 21'd8, 64'd0, 5'd31);
  endtask

  task automatic t_jump;
    issue("R9 jump misaligned", 1, 2'd3, 3'd0, 64'd0, 21'd0, 64'h0000_1234_5678_9ABF, 5'd26);
    issue("R9 R10 jump zero reg", 1, 2'd3, 3'd0, 64'd0, 21'd0, 64'hFFFF_FFFF_FFFF_FFFE, 5'd31);
    issue("R2 after jump", 1, 2'd0, 3'd0, 64'd0, 21'd0, 64'd0, 5'd0);
  endtask

  initial begin
    en = 0; cls = 0; cnd = 0; tval = 0; disp = 0; jval = 0; lidx = 0;
    exp_pc = RST_VEC;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_seq();
    t_hold();
    t_lowbit();
    t_signed();
    t_reach();
    t_call();
    t_jump();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule